// File: doc/BRIEF.md
# Input Capture Channel with Coherent Byte Readout

This block timestamps transitions on an asynchronous input pin against a 16-bit free-running counter. The counter advances once every few bus clocks through a prescaler. The pin passes through a flop synchronizer and then through an edge detector. A configuration input selects whether the detector responds to rising or to falling transitions. On each qualifying transition, a delayed copy of the counter plus one is latched into a read-only capture register, and a capture flag is raised.

Software reads the 16-bit result over an 8-bit read port. A read of the upper byte freezes the capture register until the lower byte has been read, so the two bytes always belong to one event. A transition that arrives while the register is frozen is dropped. A transition that arrives while the flag is still pending overwrites the register, so the register always holds the latest accepted event.

Top module: `icu_top`

## Requirements
- R1: After reset `ctr_value` is 0xFFFC. It increments by one on every fourth rising clock edge, counted from the release of reset, and wraps from 0xFFFF to 0x0000.
- R2: `rd_data` is combinational from `rd_addr` and follows this map:
  - `rd_addr`=1 returns the upper capture byte.
  - `rd_addr`=2 returns the lower capture byte.
  - `rd_addr`=0 returns status, with the capture flag in bit 7 and zeros in the other bits.
- R3: With `edge_rise`=1 only a 0-to-1 pin transition captures. With `edge_rise`=0 only a 1-to-0 transition captures. A transition in the other direction leaves the register and the flag unchanged.
- R4: The captured value equals one plus the `ctr_value` seen in the clock cycle in which the pin changed. The register and the flag are updated on the third rising edge after the change.
- R5: A qualifying transition overwrites the capture register even when the flag is already set.
- R6: A read of the upper byte blocks captures from that edge until the edge that completes a lower-byte read. Transitions detected in that window are discarded and do not set the flag.
- R7: A read of the lower byte without a preceding upper-byte read does not block later captures.
- R8: Reset clears the flag. Every capture sets the flag. The flag is cleared only by a lower-byte read that follows a status read made while the flag was set. A lower-byte read without that status read leaves the flag set.
- R9: `irq` is high exactly when the flag is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_rise | input | 1 | 1 selects rising transitions, 0 selects falling |
| irq_en | input | 1 | Capture interrupt enable |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| rd_addr | input | 2 | Read address (0 status, 1 upper byte, 2 lower byte) |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| ctr_value | output | 16 | Free-running counter value |
| irq | output | 1 | Capture interrupt request |

## Verification
A capture is due on the third rising edge after the pin changes. This allows two synchronizer flops and one edge-detector stage, with a counter delay line of matching depth. The bench therefore changes the pin at a falling edge, records `ctr_value` at that moment, and waits three rising edges before sampling at the following falling edge.

Read data is combinational. It is sampled in the same cycle as the strobe. The effects of a read (lock, arm, flag clear) are due at the rising edge that ends the strobe, so the bench observes them from the next falling edge.

Counter steps are checked at fixed edge counts after the release of reset. These counts include the step that wraps to zero.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 2'd0,
    RA_CAP_HI = 2'd1,
    RA_CAP_LO = 2'd2,
    RA_NONE   = 2'd3
  } rd_addr_e;
  localparam int FLAG_BIT = 7;
endpackage

// File: rtl/icu_free_ctr.sv
module icu_free_ctr #(
  parameter int          CTR_W   = 16,
  parameter int          PRE_DIV = 4,
  parameter logic [15:0] CTR_RST = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick,
  output logic [CTR_W-1:0] ctr
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  function automatic logic [CTR_W-1:0] step(input logic [CTR_W-1:0] c);
    return c + CTR_W'(1);
  endfunction

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      ctr   <= CTR_W'(CTR_RST);
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) ctr <= step(ctr);
    end
  end

  // R1
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr != $past(ctr)) |-> (ctr == $past(ctr) + CTR_W'(1)));
  // R1
  ctr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr != $past(ctr)) |-> (pre_q == '0));
endmodule

// File: rtl/icu_edge_det.sv
module icu_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_evt
);
  logic [SYNC_N:0] s_q;
  logic            now_lvl, old_lvl;

  always_ff @(posedge clk) begin
    if (rst) s_q <= '0;
    else     s_q <= {s_q[SYNC_N-1:0], pin};
  end

  assign now_lvl  = s_q[SYNC_N-1];
  assign old_lvl  = s_q[SYNC_N];
  assign edge_evt = rise_sel ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);

  // R3
  edge_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    edge_evt |=> !(edge_evt && $stable(rise_sel)));
endmodule

// File: rtl/icu_cap_regs.sv
module icu_cap_regs
  import icu_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               edge_evt,
  input  logic [2*BUS_W-1:0] ctr,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               irq_en,
  output logic [BUS_W-1:0]   rd_data,
  output logic               irq
);
  localparam int CTR_W = 2 * BUS_W;

  logic [CTR_W-1:0] dly_q [SYNC_N];
  logic [CTR_W-1:0] cap_q;
  logic             lock_q, arm_q, flag_q;
  logic             hi_read, lo_read, st_read, blocked, cap_evt, flag_clr;

  function automatic logic [CTR_W-1:0] sync_adj(input logic [CTR_W-1:0] c);
    return c + CTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    dly_q[0] <= ctr;
    for (int i = 1; i < SYNC_N; i++) dly_q[i] <= dly_q[i-1];
  end

  assign hi_read  = rd_en && (rd_addr == RA_CAP_HI);
  assign lo_read  = rd_en && (rd_addr == RA_CAP_LO);
  assign st_read  = rd_en && (rd_addr == RA_STATUS);
  assign blocked  = lock_q | hi_read;
  assign cap_evt  = edge_evt & ~blocked;
  assign flag_clr = lo_read & arm_q;

  always_ff @(posedge clk) begin
    if (cap_evt) cap_q <= sync_adj(dly_q[SYNC_N-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (lo_read)      lock_q <= 1'b0;
      else if (hi_read) lock_q <= 1'b1;
      if (lo_read)                arm_q <= 1'b0;
      else if (st_read && flag_q) arm_q <= 1'b1;
      if (cap_evt)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_STATUS: rd_data[FLAG_BIT] = flag_q;
      RA_CAP_HI: rd_data = cap_q[CTR_W-1:BUS_W];
      RA_CAP_LO: rd_data = cap_q[BUS_W-1:0];
      default:   rd_data = '0;
    endcase
  end

  assign irq = flag_q & irq_en;

  // R6
  cap_hold_locked_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(cap_q));
  // R8
  flag_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flag_q);
  // R8
  flag_clear_path_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(lo_read && arm_q));
  // R6
  lock_needs_hi_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(hi_read));
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int          BUS_W   = 8,
  parameter int          PRE_DIV = 4,
  parameter int          SYNC_N  = 2,
  parameter logic [15:0] CTR_RST = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_pin,
  input  logic               edge_rise,
  input  logic               irq_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BUS_W-1:0]   rd_data,
  output logic [2*BUS_W-1:0] ctr_value,
  output logic               irq
);
  localparam int CTR_W = 2 * BUS_W;

  logic tick;
  logic edge_evt;

  icu_free_ctr #(.CTR_W(CTR_W), .PRE_DIV(PRE_DIV), .CTR_RST(CTR_RST)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick), .ctr(ctr_value));

  icu_edge_det #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .pin(cap_pin), .rise_sel(edge_rise), .edge_evt(edge_evt));

  icu_cap_regs #(.BUS_W(BUS_W), .SYNC_N(SYNC_N)) u_regs (
    .clk(clk), .rst(rst), .edge_evt(edge_evt), .ctr(ctr_value),
    .rd_en(rd_en), .rd_addr(rd_addr), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq));

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: tb/test_icu_top.sv
module test_icu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin = 1'b0;
  logic        edge_rise = 1'b1;
  logic        irq_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd3;
  logic [7:0]  rd_data;
  logic [15:0] ctr_value;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  icu_top i_icu_top (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .edge_rise(edge_rise),
    .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctr_value(ctr_value), .irq(irq));

  typedef struct packed { logic rise; logic pin; logic hit; } vec_t;
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b1, 1'b1}, '{1'b1, 1'b0, 1'b0}, '{1'b0, 1'b1, 1'b0}, '{1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1}, '{1'b0, 1'b0, 1'b1}, '{1'b0, 1'b1, 1'b0}, '{1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; rd_addr = 2'd3;
  endtask

  task automatic pin_to(input logic v, output logic [15:0] exp_cap);
    cap_pin = v;
    exp_cap = ctr_value + 16'd1;
    edges(3);
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(2'd1, h);
    bus_rd(2'd2, l);
    v = {h, l};
  endtask

  task automatic flag_of(output logic f);
    logic [7:0] s;
    bus_rd(2'd0, s);
    f = s[7];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] exp_cap, last_cap, got;
    logic        f;
    last_cap = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 R8 R9 reset state
    chk(ctr_value == 16'hFFFC, "R1 reset count", ctr_value, 16'hFFFC);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);
    edges(3);
    chk(ctr_value == 16'hFFFC, "R1 hold 3 edges", ctr_value, 16'hFFFC);
    edges(1);
    chk(ctr_value == 16'hFFFD, "R1 step 4th edge", ctr_value, 16'hFFFD);
    edges(12);
    chk(ctr_value == 16'h0000, "R1 wrap", ctr_value, 16'h0000);
    flag_of(f);
    chk(f == 1'b0, "R8 reset flag", f, 0);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      edge_rise = VEC[i].rise;
      edges(2);
      pin_to(VEC[i].pin, exp_cap);
      flag_of(f);
      chk(f == VEC[i].hit, "R3 flag after edge", f, VEC[i].hit);
      read_cap(got);
      if (VEC[i].hit) last_cap = exp_cap;
      chk(got == last_cap, "R4 captured value", got, last_cap);
      flag_of(f);
      chk(f == 1'b0, "R8 cleared by status+low read", f, 0);
    end

    // R5 overwrite with flag pending; pin is 0 here
    edge_rise = 1'b1;
    edges(2);
    pin_to(1'b1, exp_cap);
    edge_rise = 1'b0;
    edges(5);
    pin_to(1'b0, exp_cap);
    flag_of(f);
    chk(f == 1'b1, "R5 flag still set", f, 1);
    read_cap(got);
    chk(got == exp_cap, "R5 overwrite", got, exp_cap);
    last_cap = got;

    // R6 high read blocks and discards; pin 0, edge_rise 0
    edge_rise = 1'b1;
    edges(2);
    bus_rd(2'd1, got[15:8]);
    pin_to(1'b1, exp_cap);
    edges(4);
    bus_rd(2'd2, got[7:0]);
    chk(got == last_cap, "R6 coherent pair", got, last_cap);
    flag_of(f);
    chk(f == 1'b0, "R6 no flag while locked", f, 0);
    read_cap(got);
    chk(got == last_cap, "R6 edge discarded", got, last_cap);

    // R7 low read alone does not block; pin 1 now, falling mode
    edge_rise = 1'b0;
    edges(2);
    bus_rd(2'd2, got[7:0]);
    pin_to(1'b0, exp_cap);
    flag_of(f);
    chk(f == 1'b1, "R7 capture after low read", f, 1);
    // R9 interrupt request
    irq_en = 1'b1; #1;
    chk(irq == 1'b1, "R9 irq with enable", irq, 1);
    irq_en = 1'b0; #1;
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    @(negedge clk);
    read_cap(got);
    chk(got == exp_cap, "R7 captured value", got, exp_cap);

    // R8 low read without status read keeps flag
    edge_rise = 1'b1;
    edges(2);
    pin_to(1'b1, exp_cap);
    read_cap(got);
    flag_of(f);
    chk(f == 1'b1, "R8 flag kept without status read", f, 1);
    bus_rd(2'd2, got[7:0]);
    flag_of(f);
    chk(f == 1'b0, "R8 flag cleared", f, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule